// File: doc/BRIEF.md
# Eight-Cell Lookup-Table Tile with Upward Carry

This block is one configurable logic tile of a small programmable fabric. It stacks eight logic cells vertically. Each cell evaluates a 4-input lookup table. The cell can then either pass that result straight to its output or capture it in a flip-flop. A dedicated carry path runs from the lowest cell to the highest. A column of tiles can therefore form a ripple adder without going through general routing. The path enters at `carry_in` and leaves at `carry_out`, so it extends across tiles.

All configuration comes in on one flat, static bus. Each cell uses a 20-bit slice of it, and the slice for cell i starts at bit 20*i. Inside a slice, bits [15:0] hold the truth table. Bit 16 selects carry mode and bit 17 selects the combinational output. Bit 18 inverts the reset polarity and bit 19 makes the flip-flop obey the enable. The clock, reset and enable are shared by all eight flip-flops and are meant to be driven from global lines. The tile carries no data stream, so every pin is a plain level signal with no handshake.

Top module: `lut_tile`

## Requirements
- R1: With bit 16 = 0 and bit 17 = 1, `cell_out[i]` equals truth-table bit number {in3,in2,in1,in0}, where in0 is `lut_in[4*i]` and in3 is `lut_in[4*i+3]`.
- R2: With bit 16 = 1, the cell result is the table output (propagate) XOR the carry entering that cell.
- R3: With bit 16 = 1, the carry leaving a cell is the entering carry when propagate is 1, and in0 when propagate is 0. The carry runs from cell 0 upward, and `carry_out` is the carry leaving cell 7.
- R4: A cell with bit 16 = 0 forwards its entering carry unchanged, so a tile with no carry-mode cell has `carry_out` equal to `carry_in`.
- R5: With bit 17 = 0, `cell_out[i]` is registered. It shows the cell result captured at the rising edge of `clk`, and it keeps its old value until that edge.
- R6: The flip-flop reset is synchronous and clears the register to 0. It is asserted when `tile_rst` XOR bit 18 is 1, and it wins over the enable.
- R7: With bit 19 = 1, the flip-flop loads only while `tile_en` is 1 and otherwise holds. With bit 19 = 0, `tile_en` has no effect.
- R8: With every cell in carry mode and in combinational output, table 16'h6666, in0 = a[i] and in1 = b[i], the tile outputs {`carry_out`, `cell_out`} = a + b + `carry_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tile clock for all cell flip-flops |
| tile_rst | input | 1 | Shared reset line; the polarity is chosen per cell |
| tile_en | input | 1 | Shared clock-enable line |
| cfg_bits | input | 160 | Static configuration, 20 bits per cell |
| lut_in | input | 32 | Four table inputs per cell, cell i at [4i+3:4i] |
| carry_in | input | 1 | Carry entering cell 0 |
| cell_out | output | 8 | One output per cell |
| carry_out | output | 1 | Carry leaving cell 7 |

## Verification
Combinational results (R1–R4, R8) are due in the same cycle as the stimulus. The bench changes inputs on a falling edge and samples 2 ns later, well before the next rising edge. Registered results (R5–R7) are due at the first rising edge after the stimulus, so the bench samples 1 ns after that edge. In one case the bench also samples just before the edge to confirm the old value is still held.

// File: rtl/lut_tile_pkg.sv
package lut_tile_pkg;
  localparam int LUT_K      = 4;
  localparam int LUT_BITS   = 1 << LUT_K;
  localparam int CELL_CFG_W = LUT_BITS + 4;

  // Per-cell configuration slice, MSB first: enable-use, reset invert,
  // combinational select, carry mode, truth table.
  typedef struct packed {
    logic                en_use;
    logic                rst_inv;
    logic                comb_sel;
    logic                carry_en;
    logic [LUT_BITS-1:0] table_bits;
  } cell_cfg_t;
endpackage

// File: rtl/lut_k.sv
module lut_k #(
  parameter int K = 4
) (
  input  logic [(1<<K)-1:0] truth,
  input  logic [K-1:0]      sel,
  output logic              y
);
  assign y = truth[sel];
endmodule

// File: rtl/logic_cell.sv
module logic_cell
  import lut_tile_pkg::*;
(
  input  logic             clk,
  input  logic             tile_rst,
  input  logic             tile_en,
  input  cell_cfg_t        cfg,
  input  logic [LUT_K-1:0] ins,
  input  logic             cin,
  output logic             out,
  output logic             cout
);
  logic prop, gen, result, rst_req, load, q;

  lut_k #(.K(LUT_K)) u_lut (
    .truth (cfg.table_bits),
    .sel   (ins),
    .y     (prop)
  );

  // Generate comes straight from input 0: when propagate is low,
  // both addend bits agree, so either one is the carry.
  assign gen    = ins[0];
  assign result = cfg.carry_en ? (prop ^ cin) : prop;
  assign cout   = cfg.carry_en ? (prop ? cin : gen) : cin;

  assign rst_req = tile_rst ^ cfg.rst_inv;
  assign load    = !cfg.en_use || tile_en;

  always_ff @(posedge clk) begin
    if (rst_req)   q <= 1'b0;
    else if (load) q <= result;
  end

  assign out = cfg.comb_sel ? result : q;
endmodule

// File: rtl/lut_tile.sv
module lut_tile
  import lut_tile_pkg::*;
#(
  parameter int NUM_CELLS = 8,
  localparam int CFG_W    = NUM_CELLS * CELL_CFG_W,
  localparam int IN_W     = NUM_CELLS * LUT_K
) (
  input  logic                 clk,
  input  logic                 tile_rst,
  input  logic                 tile_en,
  input  logic [CFG_W-1:0]     cfg_bits,
  input  logic [IN_W-1:0]      lut_in,
  input  logic                 carry_in,
  output logic [NUM_CELLS-1:0] cell_out,
  output logic                 carry_out
);
  logic [NUM_CELLS:0] chain;

  assign chain[0] = carry_in;

  for (genvar i = 0; i < NUM_CELLS; i++) begin : g_cell
    cell_cfg_t ccfg;
    assign ccfg = cell_cfg_t'(cfg_bits[i*CELL_CFG_W +: CELL_CFG_W]);

    logic_cell u_cell (
      .clk      (clk),
      .tile_rst (tile_rst),
      .tile_en  (tile_en),
      .cfg      (ccfg),
      .ins      (lut_in[i*LUT_K +: LUT_K]),
      .cin      (chain[i]),
      .out      (cell_out[i]),
      .cout     (chain[i+1])
    );
  end

  assign carry_out = chain[NUM_CELLS];
endmodule

// File: rtl/lut_tile_chk.sv
module lut_tile_chk
  import lut_tile_pkg::*;
#(
  parameter int NUM_CELLS = 8,
  localparam int CFG_W    = NUM_CELLS * CELL_CFG_W,
  localparam int IN_W     = NUM_CELLS * LUT_K
) (
  input logic                 clk,
  input logic                 tile_rst,
  input logic                 tile_en,
  input logic [CFG_W-1:0]     cfg_bits,
  input logic [IN_W-1:0]      lut_in,
  input logic                 carry_in,
  input logic [NUM_CELLS-1:0] cell_out,
  input logic                 carry_out
);
  // The tile has no reset of its own, so properties wait for a first edge.
  logic seen_edge = 1'b0;
  always_ff @(posedge clk) seen_edge <= 1'b1;

  logic any_carry;
  always_comb begin
    any_carry = 1'b0;
    for (int i = 0; i < NUM_CELLS; i++)
      any_carry = any_carry | cfg_bits[i*CELL_CFG_W + LUT_BITS];
  end

  p_carry_pass_r4: assert property (@(posedge clk) disable iff (!seen_edge)
    !any_carry |-> (carry_out == carry_in));

  for (genvar i = 0; i < NUM_CELLS; i++) begin : g_chk
    cell_cfg_t c;
    assign c = cell_cfg_t'(cfg_bits[i*CELL_CFG_W +: CELL_CFG_W]);

    p_comb_table_r1: assert property (@(posedge clk) disable iff (!seen_edge)
      (c.comb_sel && !c.carry_en) |->
        (cell_out[i] == c.table_bits[lut_in[i*LUT_K +: LUT_K]]));

    p_reset_clears_r6: assert property (@(posedge clk) disable iff (!seen_edge)
      (!c.comb_sel && (tile_rst ^ c.rst_inv)) |=>
        (cfg_bits != $past(cfg_bits)) || !cell_out[i]);

    p_enable_hold_r7: assert property (@(posedge clk) disable iff (!seen_edge)
      (!c.comb_sel && c.en_use && !tile_en && !(tile_rst ^ c.rst_inv)) |=>
        (cfg_bits != $past(cfg_bits)) || $stable(cell_out[i]));
  end
endmodule

bind lut_tile lut_tile_chk #(.NUM_CELLS(NUM_CELLS)) u_chk (
  .clk       (clk),
  .tile_rst  (tile_rst),
  .tile_en   (tile_en),
  .cfg_bits  (cfg_bits),
  .lut_in    (lut_in),
  .carry_in  (carry_in),
  .cell_out  (cell_out),
  .carry_out (carry_out)
);

// File: tb/lut_tile_tb.sv
`timescale 1ns/1ps
module lut_tile_tb;
  localparam int N  = 8;
  localparam int CW = 20;

  logic           clk = 1'b0;
  logic           tile_rst = 1'b0;
  logic           tile_en = 1'b0;
  logic [N*CW-1:0] cfg_bits = '0;
  logic [N*4-1:0] lut_in = '0;
  logic           carry_in = 1'b0;
  logic [N-1:0]   cell_out;
  logic           carry_out;

  int n_vec = 0;
  int n_err = 0;

  always #4 clk = ~clk;

  lut_tile #(.NUM_CELLS(N)) u_dut (
    .clk(clk), .tile_rst(tile_rst), .tile_en(tile_en), .cfg_bits(cfg_bits),
    .lut_in(lut_in), .carry_in(carry_in), .cell_out(cell_out), .carry_out(carry_out)
  );

  // {a, b, cin}
  localparam logic [16:0] ADD_VEC [10] = '{
    {8'h00, 8'h00, 1'b0}, {8'h01, 8'h01, 1'b0}, {8'hFF, 8'h01, 1'b0},
    {8'hFF, 8'h00, 1'b1}, {8'h7F, 8'h7F, 1'b1}, {8'hA5, 8'h5A, 1'b0},
    {8'hA5, 8'h5A, 1'b1}, {8'h80, 8'h80, 1'b0}, {8'h3C, 8'h99, 1'b1},
    {8'hFF, 8'hFF, 1'b1}
  };

  function automatic logic [CW-1:0] mk(input logic en_use, input logic rinv,
      input logic comb, input logic carry, input logic [15:0] tbl);
    return {en_use, rinv, comb, carry, tbl};
  endfunction

  function automatic logic [N*CW-1:0] all_cells(input logic [CW-1:0] c);
    logic [N*CW-1:0] r;
    for (int i = 0; i < N; i++) r[i*CW +: CW] = c;
    return r;
  endfunction

  function automatic logic [N*4-1:0] pack_ab(input logic [7:0] a, input logic [7:0] b);
    logic [N*4-1:0] r;
    for (int i = 0; i < N; i++) r[i*4 +: 4] = {2'b00, b[i], a[i]};
    return r;
  endfunction

  task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic reg_step(input logic r, input logic e, input logic [7:0] a);
    @(negedge clk);
    tile_rst = r; tile_en = e; lut_in = pack_ab(a, 8'hFF);
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

  initial begin
    // Reset state, registered AND cells (table 8888), enable used.
    cfg_bits = all_cells(mk(1'b1, 1'b0, 1'b0, 1'b0, 16'h8888));
    reg_step(1'b1, 1'b0, 8'hFF);
    chk("R6 reset state", {1'b0, cell_out}, 9'h000);
    reg_step(1'b0, 1'b0, 8'hFF);
    chk("R7 hold while enable low", {1'b0, cell_out}, 9'h000);
    reg_step(1'b0, 1'b1, 8'hFF);
    chk("R5 load on edge", {1'b0, cell_out}, 9'h0FF);
    reg_step(1'b1, 1'b1, 8'hFF);
    chk("R6 reset beats enable", {1'b0, cell_out}, 9'h000);
    @(negedge clk);
    tile_rst = 1'b0; tile_en = 1'b1; lut_in = pack_ab(8'hA5, 8'hFF);
    #2 chk("R5 old value before edge", {1'b0, cell_out}, 9'h000);
    @(posedge clk); #1;
    chk("R5 new value after edge", {1'b0, cell_out}, 9'h0A5);
    reg_step(1'b0, 1'b0, 8'h3C);
    chk("R7 hold keeps A5", {1'b0, cell_out}, 9'h0A5);
    cfg_bits = all_cells(mk(1'b0, 1'b0, 1'b0, 1'b0, 16'h8888));
    reg_step(1'b0, 1'b0, 8'h3C);
    chk("R7 enable ignored", {1'b0, cell_out}, 9'h03C);
    cfg_bits = all_cells(mk(1'b0, 1'b1, 1'b0, 1'b0, 16'h8888));
    reg_step(1'b1, 1'b0, 8'h0F);
    chk("R6 inverted, high line not reset", {1'b0, cell_out}, 9'h00F);
    reg_step(1'b0, 1'b0, 8'h0F);
    chk("R6 inverted, low line resets", {1'b0, cell_out}, 9'h000);

    // Adder vectors (R8, R2, R3).
    cfg_bits = all_cells(mk(1'b0, 1'b0, 1'b1, 1'b1, 16'h6666));
    for (int v = 0; v < 10; v++) begin
      logic [7:0] a, b; logic ci; logic [8:0] sum;
      {a, b, ci} = ADD_VEC[v];
      sum = {1'b0, a} + {1'b0, b} + {8'h00, ci};
      @(negedge clk);
      lut_in = pack_ab(a, b); carry_in = ci;
      #2;
      chk("R8/R2 sum bits", {1'b0, cell_out}, {1'b0, sum[7:0]});
      chk("R3 carry out", {8'h00, carry_out}, {8'h00, sum[8]});
    end

    // Arbitrary truth tables, combinational, no carry (R1).
    for (int i = 0; i < N; i++)
      cfg_bits[i*CW +: CW] = mk(1'b0, 1'b0, 1'b1, 1'b0,
                                 (16'hA5C3 << i) | (16'hA5C3 >> (16 - i)));
    for (int idx = 0; idx < 16; idx++) begin
      logic [7:0] exp;
      for (int i = 0; i < N; i++) begin
        logic [15:0] t;
        t = (16'hA5C3 << i) | (16'hA5C3 >> (16 - i));
        exp[i] = t[idx];
      end
      @(negedge clk);
      for (int i = 0; i < N; i++) lut_in[i*4 +: 4] = idx[3:0];
      #2 chk("R1 truth table", {1'b0, cell_out}, {1'b0, exp});
    end

    // Carry pass-through with no carry-mode cell (R4).
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      carry_in = k[0];
      #2 chk("R4 carry forwarded", {8'h00, carry_out}, {8'h00, k[0]});
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule